// File: doc/BRIEF.md
# Byte-Stream PC Serial Port Register Emulator

This block presents the eight-register programming view of a classic PC serial port on a small CPU bus. The bus has a 3-bit offset, a write strobe, a read strobe and 8-bit data. Characters do not pass through a bit shifter. Bytes arrive on a receive byte stream and are held in the receive buffer. A write to the transmit holding register comes out as a one-cycle pulse on a transmit byte stream. Software written for the legacy port therefore sees the register layout, reset state, divisor banking and interrupt-identification behaviour it expects.

Bit 7 of the line control register selects the bank. When it is set, offsets 0 and 1 reach the two divisor bytes instead of the data and interrupt-enable registers. The interrupt-identification register records one pending source at a time, as a type code with an active-low pending flag. The interrupt output is asserted while that flag is low. The FIFO control register drives one-cycle flush pulses and a decoded receive trigger level to the surrounding byte queues. The modem status register samples four modem inputs and records their changes in delta bits.

Top module: `uart_regfile_emu`

## Requirements
- R1: After reset, reading offsets 0..7 with bank bit 0 returns 0x00, 0x00, 0x41, 0x03, 0x00, 0x60, 0x10, 0x00. With bank bit 1, offset 0 returns divisor low 0x00 and offset 1 returns divisor high 0x01.
- R2: Line control bit 7 is the bank bit. When it is 1, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. When it is 0, offset 1 is the interrupt enable register, offset 0 reads the receive buffer and offset 0 writes the transmit holding register. Offsets 3, 4 and 7 are plain read/write registers.
- R3: Offset 2 reads the interrupt identification register in either bank. A write to offset 2 goes only to the FIFO control register, whose bits 7:6 set rx_trigger: 00→1, 01→4, 10→8, 11→14.
- R4: Writing FIFO control bit 1 (or bit 2) makes rx_flush (or tx_flush) high for exactly the next cycle, after which the bit clears itself.
- R5: A byte on the receive stream is loaded into the receive buffer and sets line status bit 0. If interrupt-enable bit 0 is 1, it also writes type 010 into identification bits 3:1 and clears bit 0.
- R6: tx_take sets line status bits 5 and 6. If interrupt-enable bit 1 is 1, it also writes type 001 and clears identification bit 0.
- R7: A read of the receive buffer clears line status bit 0. A write of the transmit holding register clears line status bits 5 and 6. Each of these also sets identification bit 0, but only when its own type (010 or 001) is the one recorded and pending; otherwise the identification register is unchanged.
- R8: A transmit holding write drives tx_valid high for one cycle, with tx_byte equal to the written byte. An offset-0 write with bank bit 1 gives no pulse.
- R9: Modem status bits 7:4 follow modem_in[3:0] (bit0 clear-to-send, bit1 data-set-ready, bit2 ring, bit3 carrier). Delta bits 0, 1 and 3 set on any change of bits 4, 5 and 7. Delta bit 2 sets on a 1→0 ring transition. A read of offset 6 clears all four delta bits.
- R10: irq is high exactly when identification bit 0 is 0.
- R11: Writes to offsets 5 and 6 change nothing.
- R12: Within a single cycle, a set beats a clear: a new byte beats a buffer read, and tx_take beats a holding write. When the receive and transmit sets coincide, type 010 is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (for side effects; data is combinational) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| rx_valid | input | 1 | Receive byte present |
| rx_byte | input | 8 | Receive byte |
| tx_take | input | 1 | Downstream consumed the held transmit byte |
| tx_valid | output | 1 | Transmit byte pulse |
| tx_byte | output | 8 | Transmit byte |
| modem_in | input | 4 | Modem inputs: CTS, DSR, RI, DCD |
| rx_flush | output | 1 | Receive queue flush pulse |
| tx_flush | output | 1 | Transmit queue flush pulse |
| rx_trigger | output | 4 | Decoded receive trigger level |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default divisor reset value of 0x0100. That lets the divisor bank reads be checked against the classic reset state, high byte 0x01 and low byte 0x00. The 8-bit data width and 3-bit offset are kept, so all eight offsets in both banks can be peeked without read side effects. A behavioural model follows the interrupt identification state through matched and mismatched clears, same-cycle set collisions, all four trigger codes and every modem delta edge.

// File: rtl/uart_emu_pkg.sv
package uart_emu_pkg;
    localparam int DW = 8;
    localparam int AW = 3;
    localparam int MW = 4;

    typedef logic [DW-1:0] byte_t;

    localparam logic [AW-1:0] OFS_DATA  = 3'd0;
    localparam logic [AW-1:0] OFS_IEN   = 3'd1;
    localparam logic [AW-1:0] OFS_IDFC  = 3'd2;
    localparam logic [AW-1:0] OFS_LCTL  = 3'd3;
    localparam logic [AW-1:0] OFS_MCTL  = 3'd4;
    localparam logic [AW-1:0] OFS_LSTAT = 3'd5;
    localparam logic [AW-1:0] OFS_MSTAT = 3'd6;
    localparam logic [AW-1:0] OFS_SCR   = 3'd7;

    localparam logic [2:0] ITYPE_TXE = 3'b001;
    localparam logic [2:0] ITYPE_RXD = 3'b010;

    localparam byte_t IID_RST   = 8'h41;
    localparam byte_t LCTL_RST  = 8'h03;
    localparam byte_t LSTAT_RST = 8'h60;
    localparam byte_t MSTAT_RST = 8'h10;

    localparam int BANK_BIT = 7;
endpackage

// File: rtl/uart_emu_intid.sv
module uart_emu_intid
    import uart_emu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rx_en,
    input  logic  tx_en,
    input  logic  set_rx,
    input  logic  set_tx,
    input  logic  clr_rx,
    input  logic  clr_tx,
    output byte_t iid
);
    byte_t iid_d, iid_q;

    always_comb begin
        iid_d = iid_q;
        if (clr_rx && iid_d[3:1] == ITYPE_RXD && !iid_d[0]) iid_d[0] = 1'b1;
        if (clr_tx && iid_d[3:1] == ITYPE_TXE && !iid_d[0]) iid_d[0] = 1'b1;
        if (set_tx && tx_en) begin
            iid_d[3:1] = ITYPE_TXE;
            iid_d[0]   = 1'b0;
        end
        if (set_rx && rx_en) begin
            iid_d[3:1] = ITYPE_RXD;
            iid_d[0]   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) iid_q <= IID_RST;
        else        iid_q <= iid_d;
    end

    assign iid = iid_q;

    // R5 R6
    pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iid_q[0]) |-> $past((set_rx && rx_en) || (set_tx && tx_en)));

    // R7
    clr_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rx && !clr_tx && !set_rx && !set_tx &&
         !(iid_q[3:1] == ITYPE_RXD && !iid_q[0])) |=> $stable(iid_q));
endmodule

// File: rtl/uart_emu_mstat.sv
module uart_emu_mstat
    import uart_emu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] modem_in,
    input  logic          rd_clr,
    output byte_t         mstat
);
    byte_t ms_d, ms_q;

    always_comb begin
        ms_d = ms_q;
        if (rd_clr) ms_d[3:0] = '0;
        ms_d[0] = ms_d[0] | (modem_in[0] ^ ms_q[4]);
        ms_d[1] = ms_d[1] | (modem_in[1] ^ ms_q[5]);
        ms_d[2] = ms_d[2] | (ms_q[6] & ~modem_in[2]);
        ms_d[3] = ms_d[3] | (modem_in[3] ^ ms_q[7]);
        ms_d[7:4] = modem_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ms_q <= MSTAT_RST;
        else        ms_q <= ms_d;
    end

    assign mstat = ms_q;

    // R9
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (modem_in == ms_q[7:4] && !rd_clr) |=> $stable(ms_q));
endmodule

// File: rtl/uart_regfile_emu.sv
module uart_regfile_emu
    import uart_emu_pkg::*;
#(
    parameter logic [2*DW-1:0] DIV_RST = 16'h0100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          tx_take,
    output logic          tx_valid,
    output logic [DW-1:0] tx_byte,
    input  logic [MW-1:0] modem_in,
    output logic          rx_flush,
    output logic          tx_flush,
    output logic [3:0]    rx_trigger,
    output logic          irq
);
    typedef struct packed {
        byte_t div_lo;
        byte_t div_hi;
        byte_t ien;
        byte_t fctl;
        byte_t lctl;
        byte_t mctl;
        byte_t scr;
        byte_t rbuf;
        byte_t lstat;
        logic  txv;
        byte_t txb;
    } regs_t;

    regs_t r_d, r_q;
    byte_t iid, mstat;
    logic  bank, rbuf_rd, thr_wr, ms_rd;

    assign bank    = r_q.lctl[BANK_BIT];
    assign rbuf_rd = bus_rd && bus_addr == OFS_DATA && !bank;
    assign thr_wr  = bus_wr && bus_addr == OFS_DATA && !bank;
    assign ms_rd   = bus_rd && bus_addr == OFS_MSTAT;

    always_comb begin
        r_d = r_q;
        r_d.txv = 1'b0;
        r_d.fctl[2:1] = 2'b00;
        if (rbuf_rd) r_d.lstat[0] = 1'b0;
        if (bus_wr) begin
            unique case (bus_addr)
                OFS_DATA: begin
                    if (bank) r_d.div_lo = bus_wdata;
                    else begin
                        r_d.txv = 1'b1;
                        r_d.txb = bus_wdata;
                        r_d.lstat[6:5] = 2'b00;
                    end
                end
                OFS_IEN:  if (bank) r_d.div_hi = bus_wdata; else r_d.ien = bus_wdata;
                OFS_IDFC: r_d.fctl = bus_wdata;
                OFS_LCTL: r_d.lctl = bus_wdata;
                OFS_MCTL: r_d.mctl = bus_wdata;
                OFS_SCR:  r_d.scr  = bus_wdata;
                default:  ;
            endcase
        end
        if (tx_take) r_d.lstat[6:5] = 2'b11;
        if (rx_valid) begin
            r_d.rbuf = rx_byte;
            r_d.lstat[0] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.div_lo <= DIV_RST[DW-1:0];
            r_q.div_hi <= DIV_RST[2*DW-1:DW];
            r_q.lctl   <= LCTL_RST;
            r_q.lstat  <= LSTAT_RST;
        end else begin
            r_q <= r_d;
        end
    end

    uart_emu_intid intid_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_en  (r_q.ien[0]),
        .tx_en  (r_q.ien[1]),
        .set_rx (rx_valid),
        .set_tx (tx_take),
        .clr_rx (rbuf_rd),
        .clr_tx (thr_wr),
        .iid    (iid)
    );

    uart_emu_mstat mstat_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .modem_in (modem_in),
        .rd_clr   (ms_rd),
        .mstat    (mstat)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_DATA:  bus_rdata = bank ? r_q.div_lo : r_q.rbuf;
            OFS_IEN:   bus_rdata = bank ? r_q.div_hi : r_q.ien;
            OFS_IDFC:  bus_rdata = iid;
            OFS_LCTL:  bus_rdata = r_q.lctl;
            OFS_MCTL:  bus_rdata = r_q.mctl;
            OFS_LSTAT: bus_rdata = r_q.lstat;
            OFS_MSTAT: bus_rdata = mstat;
            default:   bus_rdata = r_q.scr;
        endcase
    end

    always_comb begin
        unique case (r_q.fctl[7:6])
            2'b00:   rx_trigger = 4'd1;
            2'b01:   rx_trigger = 4'd4;
            2'b10:   rx_trigger = 4'd8;
            default: rx_trigger = 4'd14;
        endcase
    end

    assign rx_flush = r_q.fctl[1];
    assign tx_flush = r_q.fctl[2];
    assign tx_valid = r_q.txv;
    assign tx_byte  = r_q.txb;
    assign irq      = ~iid[0];

    // R8
    tx_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(bus_wr && bus_addr == OFS_DATA && !bank));

    // R4
    flush_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flush && !(bus_wr && bus_addr == OFS_IDFC && bus_wdata[1])) |=> !rx_flush);

    // R11
    lstat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_LSTAT && !rx_valid && !tx_take && !bus_rd)
        |=> $stable(r_q.lstat));

    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(rx_valid || tx_take));
endmodule

// File: tb/uart_regfile_emu_tb.sv
module uart_regfile_emu_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WDOG_LIMIT = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       tx_take = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic [3:0] modem_in = 4'b0001;
    logic       rx_flush, tx_flush, irq;
    logic [3:0] rx_trigger;

    int checks = 0, fails = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_regfile_emu dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_take(tx_take),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .modem_in(modem_in),
        .rx_flush(rx_flush), .tx_flush(tx_flush), .rx_trigger(rx_trigger),
        .irq(irq)
    );

    // reference model state
    logic [7:0] m_dll, m_dlh, m_ien, m_iid, m_fct, m_lct, m_mct, m_lst, m_mst, m_scr, m_rbf, m_txb;
    logic       m_txv;

    function automatic logic [7:0] m_read(input logic [2:0] a);
        logic bk = m_lct[7];
        case (a)
            3'd0: return bk ? m_dll : m_rbf;
            3'd1: return bk ? m_dlh : m_ien;
            3'd2: return m_iid;
            3'd3: return m_lct;
            3'd4: return m_mct;
            3'd5: return m_lst;
            3'd6: return m_mst;
            default: return m_scr;
        endcase
    endfunction

    function automatic logic [3:0] m_trig();
        case (m_fct[7:6])
            2'd0: return 4'd1;
            2'd1: return 4'd4;
            2'd2: return 4'd8;
            default: return 4'd14;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic m_reset();
        m_dll = 8'h00; m_dlh = 8'h01; m_ien = 0; m_iid = 8'h41; m_fct = 0;
        m_lct = 8'h03; m_mct = 0; m_lst = 8'h60; m_mst = 8'h10; m_scr = 0;
        m_rbf = 0; m_txb = 0; m_txv = 0;
    endtask

    task automatic m_update();
        logic bk = m_lct[7];
        logic [7:0] ien_old = m_ien;
        logic [7:0] mst_old = m_mst;
        logic rb_rd = bus_rd && bus_addr == 0 && !bk;
        logic th_wr = bus_wr && bus_addr == 0 && !bk;
        m_txv = 0;
        m_fct[2:1] = 0;
        if (rb_rd) m_lst[0] = 0;
        if (bus_rd && bus_addr == 6) m_mst[3:0] = 0;
        if (bus_wr) begin
            case (bus_addr)
                3'd0: if (bk) m_dll = bus_wdata;
                      else begin m_txv = 1; m_txb = bus_wdata; m_lst[6:5] = 0; end
                3'd1: if (bk) m_dlh = bus_wdata; else m_ien = bus_wdata;
                3'd2: m_fct = bus_wdata;
                3'd3: m_lct = bus_wdata;
                3'd4: m_mct = bus_wdata;
                3'd7: m_scr = bus_wdata;
                default: ;
            endcase
        end
        if (rb_rd && m_iid[3:1] == 3'b010 && !m_iid[0]) m_iid[0] = 1;
        if (th_wr && m_iid[3:1] == 3'b001 && !m_iid[0]) m_iid[0] = 1;
        if (tx_take) begin
            m_lst[6:5] = 2'b11;
            if (ien_old[1]) begin m_iid[3:1] = 3'b001; m_iid[0] = 0; end
        end
        if (rx_valid) begin
            m_rbf = rx_byte; m_lst[0] = 1;
            if (ien_old[0]) begin m_iid[3:1] = 3'b010; m_iid[0] = 0; end
        end
        if (modem_in[0] != mst_old[4]) m_mst[0] = 1;
        if (modem_in[1] != mst_old[5]) m_mst[1] = 1;
        if (mst_old[6] && !modem_in[2]) m_mst[2] = 1;
        if (modem_in[3] != mst_old[7]) m_mst[3] = 1;
        m_mst[7:4] = modem_in;
    endtask

    task automatic compare(input string req);
        chk(req, "rdata", bus_rdata, m_read(bus_addr));
        chk("R10", "irq", irq, !m_iid[0]);
        chk("R8", "tx_valid", tx_valid, m_txv);
        if (m_txv) chk("R8", "tx_byte", tx_byte, m_txb);
        chk("R4", "rx_flush", rx_flush, m_fct[1]);
        chk("R4", "tx_flush", tx_flush, m_fct[2]);
        chk("R3", "rx_trigger", rx_trigger, m_trig());
    endtask

    // one clock with the given bus/stream stimulus; compares after the edge
    task automatic step(input string req, input logic [2:0] a, input logic w, input logic r,
                        input logic [7:0] wd, input logic rv, input logic [7:0] rb, input logic tk);
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = wd;
        rx_valid = rv; rx_byte = rb; tx_take = tk;
        m_update();
        @(posedge clk); #1;
        compare(req);
        bus_wr = 0; bus_rd = 0; rx_valid = 0; tx_take = 0;
    endtask

    task automatic wr(input string req, input logic [2:0] a, input logic [7:0] d);
        step(req, a, 1, 0, d, 0, 0, 0);
    endtask
    task automatic rd(input string req, input logic [2:0] a);
        step(req, a, 0, 1, 0, 0, 0, 0);
    endtask
    task automatic peek(input string req, input logic [2:0] a);
        bus_addr = a; #1;
        chk(req, "peek", bus_rdata, m_read(a));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WDOG_LIMIT) begin
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG_LIMIT);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset view, both banks
        for (int i = 0; i < 8; i++) peek("R1", 3'(i));
        step("R1", 0, 0, 0, 0, 0, 0, 0);
        wr("R2", 3, 8'h83);
        peek("R1", 0); peek("R1", 1);
        wr("R2", 0, 8'h5A); wr("R2", 1, 8'h12);
        peek("R2", 0); peek("R2", 1); peek("R3", 2);
        wr("R8", 0, 8'h77);        // bank set: no tx pulse
        wr("R2", 3, 8'h03);
        peek("R2", 1);
        wr("R2", 4, 8'h1F); wr("R2", 7, 8'hC3);
        peek("R2", 4); peek("R2", 7);
        // R5 receive interrupt
        wr("R5", 1, 8'h03);
        step("R5", 5, 0, 0, 0, 1, 8'hA5, 0);
        peek("R5", 0); peek("R5", 2);
        rd("R7", 0);
        peek("R7", 2); peek("R7", 5);
        // R6 / R7 / R8 transmit path
        wr("R8", 0, 8'h33);
        peek("R7", 5);
        step("R6", 2, 0, 0, 0, 0, 0, 1);
        wr("R7", 0, 8'h44);
        peek("R7", 2);
        // interrupts disabled
        wr("R5", 1, 8'h00);
        step("R5", 2, 0, 0, 0, 1, 8'h11, 0);
        step("R6", 2, 0, 0, 0, 0, 0, 1);
        rd("R7", 0);
        // mismatched clear
        wr("R7", 1, 8'h03);
        step("R7", 2, 0, 0, 0, 0, 0, 1);
        rd("R7", 0);
        peek("R7", 2);
        wr("R7", 0, 8'h55);
        // R12 collisions
        step("R12", 2, 0, 0, 0, 1, 8'h66, 1);
        peek("R12", 2);
        step("R12", 0, 0, 1, 0, 1, 8'h67, 0);
        peek("R12", 5); peek("R12", 2);
        step("R12", 0, 1, 0, 8'h68, 0, 0, 1);
        peek("R12", 5);
        rd("R7", 0);
        // R3 / R4 FIFO control
        wr("R3", 2, 8'hC0); peek("R3", 2);
        wr("R3", 2, 8'h40); wr("R3", 2, 8'h80);
        wr("R4", 2, 8'h06);
        step("R4", 2, 0, 0, 0, 0, 0, 0);
        wr("R4", 2, 8'h02);
        wr("R4", 2, 8'h04);
        step("R4", 2, 0, 0, 0, 0, 0, 0);
        wr("R3", 2, 8'h00);
        // R11 read-only offsets
        wr("R11", 5, 8'h00); peek("R11", 5);
        wr("R11", 6, 8'hFF); peek("R11", 6);
        // R9 modem status
        modem_in = 4'b0110; step("R9", 6, 0, 0, 0, 0, 0, 0);
        modem_in = 4'b1010; step("R9", 6, 0, 0, 0, 0, 0, 0);
        rd("R9", 6);
        modem_in = 4'b1011; rd("R9", 6);
        step("R9", 6, 0, 0, 0, 0, 0, 0);
        modem_in = 4'b0001; step("R9", 6, 0, 0, 0, 0, 0, 0);
        rd("R9", 6);
        step("R9", 6, 0, 0, 0, 0, 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule